// File: doc/BRIEF.md
# Pulse-Transformer PWM Encoder

This block turns a peak-current trip signal into the drive pair for a small pulse transformer across an isolation barrier. A period timer running on the fast system clock divides it down to the switching period. Each period opens a positive half-cycle in which the positive pin is high and the negative pin is low. The positive half-cycle ends, and the negative half-cycle (negative pin high) begins, at the maximum-duty boundary. In encoded mode the end of the on-time is carried as a short notch inside the positive half-cycle, during which both pins are low. The pair therefore stays a complementary, near-constant square wave, so the same transformer delivers both the timing edge and bias power to the far side.

Two mode inputs are captured at every period start. One selects the encoded drive or a plain drive. In the plain drive the positive pin is an ordinary PWM pulse and the negative pin is a clock in phase with it. The other selects a maximum duty of one half or three quarters of the period. A one-cycle sync pulse restarts the period so that several encoders can share one phase reference. Dropping the enable input, which is the fault path, forces zero duty cycle at once.

The sequencer has five states. ST_IDLE is held only in reset. ST_ON marks the PWM on-time. ST_NOTCH is the zero-differential marker. ST_HOLD is the rest of the positive half-cycle. ST_NEG is the negative half-cycle. The transitions are:
- period_start: any state goes to ST_ON, or to ST_NOTCH when enable is low.
- trip_accept: ST_ON goes to ST_NOTCH.
- fault_cut: ST_ON goes to ST_NOTCH when enable falls.
- notch_done: ST_NOTCH goes to ST_HOLD.
- dmax_cut: ST_ON, ST_NOTCH or ST_HOLD goes to ST_NEG.

Top module: `pte_encoder_top`

## Requirements
- R1: While reset is asserted both drive pins are low. The first switching period starts on the first clock edge after reset is released.
- R2: In encoded mode the pins are (positive=1, negative=0) during the on-time and after the notch up to the maximum-duty boundary. They are (0,1) from that boundary until the period ends, and they are never both high.
- R3: In encoded mode the notch (both pins low) begins in the cycle right after the on-time ends and lasts NOTCH_CYC cycles. It is cut short at the maximum-duty boundary.
- R4: A trip that is high in period cycle c is accepted when MIN_ON_CYC-1 <= c <= DMAX-2, with cycle 0 being the first cycle after the period-start edge. An accepted trip gives an on-time of exactly c+1 cycles.
- R5: A trip in cycles 0 to MIN_ON_CYC-2 is ignored, so any trip-terminated on-time is at least MIN_ON_CYC cycles.
- R6: Only the first accepted trip of a period has an effect. Trips during the notch, during the rest of the positive half-cycle or during the negative half-cycle are ignored.
- R7: Without an accepted trip the on-time lasts until the maximum-duty boundary, and no notch is sent. The boundary DMAX is PERIOD_CYC/2 cycles when mode_dmax75=0 and 3*PERIOD_CYC/4 when mode_dmax75=1.
- R8: Both mode inputs are sampled only on the period-start edge. A change in the middle of a period takes effect in the next period.
- R9: In plain mode (mode_encoded=0) the positive pin is high exactly during the on-time. The negative pin is high from period start to the maximum-duty boundary.
- R10: If enable is low on the period-start edge the period has zero duty cycle. In encoded mode the notch then occupies cycles 0 to NOTCH_CYC-1.
- R11: Enable that is low in on-time cycle f ends the on-time at once: the on-time is f+1 cycles, and the minimum on-time does not apply.
- R12: A period_sync pulse high in cycle s makes cycle s+1 the cycle 0 of a new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_sync | input | 1 | One-cycle pulse that restarts the switching period |
| trip | input | 1 | Peak-current trip, ends the on-time |
| enable | input | 1 | Run enable; low means fault and forces zero duty |
| mode_encoded | input | 1 | 1 = notch-encoded drive, 0 = plain PWM plus clock |
| mode_dmax75 | input | 1 | 1 = 75 % duty limit, 0 = 50 % duty limit |
| drv_p | output | 1 | Positive transformer drive pin |
| drv_n | output | 1 | Negative transformer drive pin |

## Verification
The bench sweeps a single trip over every cycle of the period, for both drive modes and both duty limits, and predicts each pin cycle by cycle from the on-time arithmetic. This covers the exact edges of minimum-on blanking and of the maximum-duty cut. A design that is off by one there would either accept a trip one cycle inside blanking or let a trip in cycle DMAX-1 produce a notch. The sweep also covers trips close enough to the boundary that the notch must be cut short; a design that let the notch overrun would push the negative half-cycle late. Directed periods then check a second trip after the first, a mode change in mid-period, a fault inside the blanking window, a disabled period start and sync pulses. Wrong handling of these would show up as a second notch, a shifted boundary, a fault that waits out blanking, a notch that is missing at zero duty, or a period that fails to restart.

// File: rtl/pte_pkg.sv
`timescale 1ns/1ps
package pte_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ON    = 3'd1,
        ST_NOTCH = 3'd2,
        ST_HOLD  = 3'd3,
        ST_NEG   = 3'd4
    } pte_state_t;

    typedef struct packed {
        logic encoded;
        logic dmax75;
    } pte_mode_t;

endpackage

// File: rtl/pte_period_timer.sv
`timescale 1ns/1ps
module pte_period_timer
    import pte_pkg::*;
#(
    parameter int PERIOD_CYC = 64,
    parameter int CW         = $clog2(PERIOD_CYC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          period_sync,
    input  logic          mode_encoded,
    input  logic          mode_dmax75,
    output logic [CW-1:0] cnt,
    output logic          period_last,
    output logic          dmax_edge,
    output pte_mode_t     mode_q
);

    localparam int            DMAX_HALF  = PERIOD_CYC / 2;
    localparam int            DMAX_3Q    = (PERIOD_CYC * 3) / 4;
    localparam logic [CW-1:0] LAST_CNT   = CW'(PERIOD_CYC - 1);
    localparam logic [CW-1:0] HALF_LAST  = CW'(DMAX_HALF - 1);
    localparam logic [CW-1:0] THREEQ_LAST = CW'(DMAX_3Q - 1);

    logic [CW-1:0] dmax_last;

    always_comb begin
        period_last = period_sync || (cnt == LAST_CNT);
        dmax_last   = mode_q.dmax75 ? THREEQ_LAST : HALF_LAST;
        dmax_edge   = !period_last && (cnt == dmax_last);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= LAST_CNT;
            mode_q <= '0;
        end else if (period_last) begin
            cnt           <= '0;
            mode_q.encoded <= mode_encoded;
            mode_q.dmax75  <= mode_dmax75;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    // R12: a sync pulse restarts the period count on the next edge
    a_r12_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
        period_sync |=> (cnt == '0));

    // R8: the captured mode only moves on a period boundary
    a_r8_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!period_sync && cnt != LAST_CNT) |=> $stable(mode_q));

endmodule

// File: rtl/pte_sequencer.sv
`timescale 1ns/1ps
module pte_sequencer
    import pte_pkg::*;
#(
    parameter int PERIOD_CYC = 64,
    parameter int NOTCH_CYC  = 15,
    parameter int MIN_ON_CYC = 20,
    parameter int CW         = $clog2(PERIOD_CYC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic          period_last,
    input  logic          dmax_edge,
    input  logic          trip,
    input  logic          enable,
    output pte_state_t    state
);

    localparam int            NW         = $clog2(NOTCH_CYC + 1);
    localparam logic [NW-1:0] NOTCH_LAST = NW'(NOTCH_CYC - 1);
    localparam logic [CW-1:0] BLANK_END  = CW'(MIN_ON_CYC - 1);

    pte_state_t    state_n;
    logic [NW-1:0] ncnt, ncnt_n;
    logic          trip_ok;

    always_comb begin
        trip_ok = trip && (cnt >= BLANK_END);
        state_n = state;
        ncnt_n  = ncnt;
        if (period_last) begin
            state_n = enable ? ST_ON : ST_NOTCH;
            ncnt_n  = '0;
        end else begin
            unique case (state)
                ST_IDLE:  state_n = ST_IDLE;
                ST_ON: begin
                    if (dmax_edge) begin
                        state_n = ST_NEG;
                    end else if (!enable || trip_ok) begin
                        state_n = ST_NOTCH;
                        ncnt_n  = '0;
                    end
                end
                ST_NOTCH: begin
                    if (dmax_edge) begin
                        state_n = ST_NEG;
                    end else if (ncnt == NOTCH_LAST) begin
                        state_n = ST_HOLD;
                    end else begin
                        ncnt_n = ncnt + NW'(1);
                    end
                end
                ST_HOLD: begin
                    if (dmax_edge) state_n = ST_NEG;
                end
                ST_NEG:   state_n = ST_NEG;
                default:  state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ncnt  <= '0;
        end else begin
            state <= state_n;
            ncnt  <= ncnt_n;
        end
    end

    // R7: reaching the duty limit always opens the negative half-cycle
    a_r7_dmax_cut: assert property (@(posedge clk) disable iff (!rst_n)
        (dmax_edge && state != ST_IDLE) |=> (state == ST_NEG));

    // R5: no trip can end the on-time inside the blanking window
    a_r5_blanking: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ON && enable && !period_last && !dmax_edge && cnt < BLANK_END)
        |=> (state == ST_ON));

    // R3: the notch is held for its full width unless the boundary cuts it
    a_r3_notch_width: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NOTCH && ncnt != NOTCH_LAST && !dmax_edge && !period_last)
        |=> (state == ST_NOTCH));

    // R10: a disabled period start gives zero duty
    a_r10_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
        (period_last && !enable) |=> (state == ST_NOTCH));

    // R6: the negative half-cycle is left only at a new period
    a_r6_neg_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NEG && !period_last) |=> (state == ST_NEG));

endmodule

// File: rtl/pte_drive_encoder.sv
`timescale 1ns/1ps
module pte_drive_encoder
    import pte_pkg::*;
(
    input  pte_state_t state,
    input  logic       encoded,
    output logic       drv_p,
    output logic       drv_n
);

    logic pos_half;
    logic pwm_on;

    always_comb begin
        pwm_on   = (state == ST_ON);
        pos_half = (state == ST_ON) || (state == ST_NOTCH) || (state == ST_HOLD);
        if (encoded) begin
            drv_p = (state == ST_ON) || (state == ST_HOLD);
            drv_n = (state == ST_NEG);
        end else begin
            drv_p = pwm_on;
            drv_n = pos_half;
        end
    end

endmodule

// File: rtl/pte_encoder_top.sv
`timescale 1ns/1ps
module pte_encoder_top
    import pte_pkg::*;
#(
    parameter int PERIOD_CYC = 64,
    parameter int NOTCH_CYC  = 15,
    parameter int MIN_ON_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic period_sync,
    input  logic trip,
    input  logic enable,
    input  logic mode_encoded,
    input  logic mode_dmax75,
    output logic drv_p,
    output logic drv_n
);

    localparam int CW = $clog2(PERIOD_CYC);

    logic [CW-1:0] cnt;
    logic          period_last;
    logic          dmax_edge;
    pte_mode_t     mode_q;
    pte_state_t    state;

    pte_period_timer #(
        .PERIOD_CYC (PERIOD_CYC),
        .CW         (CW)
    ) timer_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_sync  (period_sync),
        .mode_encoded (mode_encoded),
        .mode_dmax75  (mode_dmax75),
        .cnt          (cnt),
        .period_last  (period_last),
        .dmax_edge    (dmax_edge),
        .mode_q       (mode_q)
    );

    pte_sequencer #(
        .PERIOD_CYC (PERIOD_CYC),
        .NOTCH_CYC  (NOTCH_CYC),
        .MIN_ON_CYC (MIN_ON_CYC),
        .CW         (CW)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt         (cnt),
        .period_last (period_last),
        .dmax_edge   (dmax_edge),
        .trip        (trip),
        .enable      (enable),
        .state       (state)
    );

    pte_drive_encoder enc_i (
        .state   (state),
        .encoded (mode_q.encoded),
        .drv_p   (drv_p),
        .drv_n   (drv_n)
    );

    // R2: the encoded pair never drives both pins high
    a_r2_never_both_high: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q.encoded |-> !(drv_p && drv_n));

    // R1: outputs are quiet on the edge after reset is applied
    a_r1_reset_quiet: assert property (@(posedge clk)
        $fell(rst_n) |=> (!drv_p && !drv_n));

endmodule

// File: tb/pte_encoder_top_tb_top.sv
`timescale 1ns/1ps
module pte_encoder_top_tb_top;

    localparam int P = 64;
    localparam int N = 15;
    localparam int M = 20;

    logic clk = 1'b0;
    logic rst_n, period_sync, trip, enable, mode_encoded, mode_dmax75;
    logic drv_p, drv_n;

    int checks = 0;
    int errors = 0;
    bit cur_enc, cur_d75, cur_en;

    always #5 clk = ~clk;

    pte_encoder_top #(.PERIOD_CYC(P), .NOTCH_CYC(N), .MIN_ON_CYC(M)) dut_i (
        .clk(clk), .rst_n(rst_n), .period_sync(period_sync), .trip(trip),
        .enable(enable), .mode_encoded(mode_encoded), .mode_dmax75(mode_dmax75),
        .drv_p(drv_p), .drv_n(drv_n)
    );

    task automatic check_pins(input string tag, input int cyc, input bit ep, input bit en);
        checks++;
        if (drv_p !== ep || drv_n !== en) begin
            errors++;
            $display("FAIL %s cycle %0d: pins p=%b n=%b expected p=%b n=%b",
                     tag, cyc, drv_p, drv_n, ep, en);
        end
    endtask

    // t1/t2: trip cycles, flt: cycle enable goes low, midc: cycle of a
    // mid-period duty-limit flip, syncc: cycle of a sync pulse (-1 = none)
    task automatic run_period(input string tag, input int t1, input int t2,
                              input int flt, input int midc, input int syncc,
                              input bit n_enc, input bit n_d75, input bit n_en);
        int d, on_end, nend, len;
        bit ep, en;
        d = cur_d75 ? (P * 3) / 4 : P / 2;
        on_end = cur_en ? d : 0;
        if (cur_en) begin
            if (t1 >= M - 1 && t1 <= d - 2 && t1 + 1 < on_end) on_end = t1 + 1;
            if (t2 >= M - 1 && t2 <= d - 2 && t2 + 1 < on_end) on_end = t2 + 1;
            if (flt >= 0 && flt + 1 < on_end) on_end = flt + 1;
        end
        nend = (on_end + N > d) ? d : on_end + N;
        len  = (syncc >= 0) ? syncc + 1 : P;
        for (int j = 0; j < len; j++) begin
            @(negedge clk);
            if (cur_enc) begin
                if (j < on_end)    begin ep = 1'b1; en = 1'b0; end
                else if (j < nend) begin ep = 1'b0; en = 1'b0; end
                else if (j < d)    begin ep = 1'b1; en = 1'b0; end
                else               begin ep = 1'b0; en = 1'b1; end
            end else begin
                ep = (j < on_end);
                en = (j < d);
            end
            check_pins(tag, j, ep, en);
            trip        = (j == t1) || (j == t2);
            period_sync = (j == syncc);
            if (flt >= 0 && j >= flt) enable = 1'b0;
            if (j == midc) mode_dmax75 = !cur_d75;
            if (j == len - 1) begin
                enable       = n_en;
                mode_encoded = n_enc;
                mode_dmax75  = n_d75;
            end
        end
        cur_enc = n_enc;
        cur_d75 = n_d75;
        cur_en  = n_en;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        string tg;
        int dd;
        rst_n = 1'b0; period_sync = 1'b0; trip = 1'b0; enable = 1'b1;
        mode_encoded = 1'b1; mode_dmax75 = 1'b0;
        cur_enc = 1'b1; cur_d75 = 1'b0; cur_en = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check_pins("R1", -1, 1'b0, 1'b0);
        end
        rst_n = 1'b1;
        // R1: first period begins right after reset release
        run_period("R1", -1, -1, -1, -1, -1, 1'b1, 1'b0, 1'b1);

        // Sweep one trip across every cycle for each mode and duty limit
        for (int e = 1; e >= 0; e--) begin
            for (int h = 0; h < 2; h++) begin
                run_period("R2", -1, -1, -1, -1, -1, bit'(e), bit'(h), 1'b1);
                dd = (h != 0) ? (P * 3) / 4 : P / 2;
                for (int c = -1; c < P; c++) begin
                    if (e == 0)               tg = "R9";
                    else if (c < 0)           tg = "R7";
                    else if (c < M - 1)       tg = "R5";
                    else if (c > dd - 2)      tg = "R7";
                    else if (c + 1 + N > dd)  tg = "R3";
                    else                      tg = "R4";
                    run_period(tg, c, -1, -1, -1, -1, bit'(e), bit'(h), 1'b1);
                end
            end
        end

        // R6: second trips and trips in the negative half-cycle
        run_period("R6", -1, -1, -1, -1, -1, 1'b1, 1'b0, 1'b1);
        run_period("R6", M + 2, M + 6, -1, -1, -1, 1'b1, 1'b0, 1'b1);
        run_period("R6", M - 5, M + 1, -1, -1, -1, 1'b1, 1'b0, 1'b1);
        run_period("R6", -1, P / 2 + 3, -1, -1, -1, 1'b1, 1'b1, 1'b1);
        run_period("R6", M + 1, M + 25, -1, -1, -1, 1'b1, 1'b1, 1'b1);

        // R8: a mid-period duty-limit flip waits for the next period
        run_period("R8", -1, -1, -1, 5, -1, 1'b1, 1'b1, 1'b1);
        run_period("R8", -1, -1, -1, 7, -1, 1'b0, 1'b0, 1'b1);
        run_period("R8", -1, -1, -1, -1, -1, 1'b1, 1'b0, 1'b0);

        // R10: disabled period starts give zero duty
        run_period("R10", M + 3, -1, -1, -1, -1, 1'b0, 1'b0, 1'b0);
        run_period("R10", -1, -1, -1, -1, -1, 1'b1, 1'b1, 1'b1);

        // R11: fault during the on-time, inside and after blanking
        run_period("R11", M + 8, -1, M + 3, -1, -1, 1'b1, 1'b0, 1'b1);
        run_period("R11", -1, -1, 2, -1, -1, 1'b0, 1'b0, 1'b1);
        run_period("R11", -1, -1, M + 4, -1, -1, 1'b1, 1'b0, 1'b1);

        // R12: sync pulses restart the period early
        run_period("R12", M + 2, -1, -1, -1, 30, 1'b1, 1'b0, 1'b1);
        run_period("R12", -1, -1, -1, -1, 10, 1'b1, 1'b1, 1'b1);
        run_period("R12", -1, -1, -1, -1, 55, 1'b1, 1'b0, 1'b1);
        run_period("R12", M, -1, -1, -1, -1, 1'b1, 1'b0, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule